// File: doc/BRIEF.md
# Periodic Tick Timer with Timestamp

This block gives a multitasking operating system its heartbeat. A prescaler divides the system clock so that 64 evenly spaced ticks happen every second. Each tick raises a maskable interrupt request, serviced at address 0x0038. Each tick also advances a 48-bit timestamp. The lowest byte of the timestamp counts fractions of a second in steps of 4, so it wraps exactly once per second. Its carry runs into a 40-bit whole-seconds count, which software may load with seconds since the Unix epoch.

The processor starts and stops the timer by writing command bytes to the shared command I/O port. It reads the timestamp one byte at a time through a small indexed read port. Reading the fraction byte freezes a copy of the seconds bytes, so a multi-byte read is always coherent. The time of day is set through a parallel load port.

Top module: `tick_timer`

## Requirements
- R1: After reset the timer is stopped, the interrupt request is low, the timestamp reads zero, and no tick occurs until an enable command is written.
- R2: Writing byte 20 to I/O address 0xFE starts the timer and restarts the prescaler. The first tick updates the timestamp at the clock edge that comes exactly DIV = CLK_HZ/64 cycles after the edge that took the write.
- R3: While the timer runs, successive ticks are exactly DIV clock cycles apart.
- R4: Writing byte 22 to I/O address 0xFE stops the timer and withdraws any pending request. After that no tick occurs and the timestamp holds.
- R5: A write to any other I/O address, or of any other byte value to 0xFE, neither starts nor stops the timer.
- R6: Each tick adds 4 to the 48-bit timestamp. Byte 0 (bits 7:0) is the fraction, and its carry moves into byte 1 (bits 15:8) and on upward.
- R7: A tick sets the interrupt request `irq_req`, which stays high until `irq_ack` is pulsed. The service vector output reads 0x0038.
- R8: A tick in the same cycle as `irq_ack` leaves `irq_req` high.
- R9: Ticks that arrive while a request is pending keep `irq_req` high and still advance the timestamp, so no tick is lost.
- R10: A load pulse replaces the timestamp with `ld_stamp`. A load in the same cycle as a tick gives `ld_stamp` + 4.
- R11: Reading index 0 returns the live fraction byte and latches bytes 1 to 5. Index k from 1 to 5 returns bits 8k+7:8k of that latched copy, even after later ticks. Indices 6 and 7 return 0.
- R12: The timestamp wraps modulo 2^48, so 0xFFFF_FFFF_FFFC plus one tick gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data byte |
| ld_en | input | 1 | Timestamp load strobe |
| ld_stamp | input | 48 | Value to load into the timestamp |
| rd_en | input | 1 | Read strobe; with index 0 it latches bytes 1 to 5 |
| rd_idx | input | 3 | Timestamp byte index |
| rd_data | output | 8 | Selected timestamp byte |
| irq_ack | input | 1 | Interrupt acknowledge from the responder |
| irq_req | output | 1 | Pending maskable interrupt request |
| irq_vector | output | 16 | Service address for the request |
| tick | output | 1 | High in the cycle that ends in a tick update |

## Verification
Two pairs of functions can fall in the same cycle: a tick with an acknowledge, and a tick with a load. The bench waits until it sees `tick` high at a falling edge, then drives `irq_ack` or `ld_stamp` in that same cycle. For the first pair it judges that the request is still high afterwards. For the second it judges that the timestamp read back equals the loaded value plus 4, plus 4 for each tick counted since.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;
  localparam int STAMP_BYTES = 6;
  localparam int STAMP_W     = 8 * STAMP_BYTES;
  localparam int IDX_W       = $clog2(STAMP_BYTES);

  typedef logic [STAMP_W-1:0] stamp_t;

  // fraction byte step per tick: one full byte wrap per second
  function automatic stamp_t stamp_advance(stamp_t s, int unsigned ticks_per_sec);
    return s + stamp_t'(256 / ticks_per_sec);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
  parameter int DIV = 781250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (cnt == LAST)      cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
      AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/tick_stamp.sv
`timescale 1ns/1ps
module tick_stamp import tick_pkg::*; #(
  parameter int TICKS_PER_SEC = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   ld_en,
  input  stamp_t ld_val,
  output stamp_t stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n)     stamp <= '0;
    else if (ld_en) stamp <= tick ? stamp_advance(ld_val, TICKS_PER_SEC) : ld_val;
    else if (tick)  stamp <= stamp_advance(stamp, TICKS_PER_SEC);
  end

  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_en |=> $stable(stamp)); // R6
  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_en |=> (stamp - $past(stamp)) == stamp_t'(4)); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !tick |=> stamp == $past(ld_val)); // R10
endmodule

// File: rtl/tick_readout.sv
`timescale 1ns/1ps
module tick_readout import tick_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  stamp_t           live,
  output logic [7:0]       rd_data
);
  logic [STAMP_W-9:0] snap_hi;
  logic               latch_now;

  assign latch_now = rd_en && (rd_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         snap_hi <= '0;
    else if (latch_now) snap_hi <= live[STAMP_W-1:8];
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx == '0) rd_data = live[7:0];
    for (int k = 1; k < STAMP_BYTES; k++) begin
      if (int'(rd_idx) == k) rd_data = snap_hi[8*(k-1) +: 8];
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_now |=> $stable(snap_hi)); // R11
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer import tick_pkg::*; #(
  parameter int          CLK_HZ        = 50_000_000,
  parameter int          TICKS_PER_SEC = 64,
  parameter logic [7:0]  CMD_PORT      = 8'hFE,
  parameter logic [7:0]  CMD_START     = 8'd20,
  parameter logic [7:0]  CMD_STOP      = 8'd22,
  parameter logic [15:0] SERVICE_ADDR  = 16'h0038
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       io_wdata,
  input  logic             ld_en,
  input  logic [STAMP_W-1:0] ld_stamp,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [15:0]      irq_vector,
  output logic             tick
);
  localparam int DIV = CLK_HZ / TICKS_PER_SEC;

  logic   port_hit, cmd_start, cmd_stop;
  logic   run;
  stamp_t stamp;

  assign port_hit  = io_wr && (io_addr == CMD_PORT);
  assign cmd_start = port_hit && (io_wdata == CMD_START);
  assign cmd_stop  = port_hit && (io_wdata == CMD_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n)         run <= 1'b0;
    else if (cmd_stop)  run <= 1'b0;
    else if (cmd_start) run <= 1'b1;
  end

  tick_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cmd_start), .tick(tick)
  );

  tick_stamp #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_stamp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en),
    .ld_val(ld_stamp), .stamp(stamp)
  );

  tick_readout u_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .live(stamp), .rd_data(rd_data)
  );

  // a new tick outranks an acknowledge; a stop command outranks both
  always_ff @(posedge clk) begin
    if (!rst_n)        irq_req <= 1'b0;
    else if (cmd_stop) irq_req <= 1'b0;
    else if (tick)     irq_req <= 1'b1;
    else if (irq_ack)  irq_req <= 1'b0;
  end

  assign irq_vector = SERVICE_ADDR;

  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(tick)); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack && !cmd_stop |=> irq_req); // R9
  AST_ACK_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && irq_ack && !cmd_stop |=> irq_req); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !irq_req && !tick); // R4
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam int CLK_HZ = 3200;
  localparam int DIV    = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic        ld_en = 1'b0;
  logic [47:0] ld_stamp = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic        tick;

  always #2 clk = ~clk;

  tick_timer #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .ld_en(ld_en), .ld_stamp(ld_stamp), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vector(irq_vector), .tick(tick)
  );

  int cyc = 0, ticks = 0, last_tick = 0, prev_tick = 0;
  always @(posedge clk) begin
    cyc++;
    if (tick) begin ticks++; prev_tick = last_tick; last_tick = cyc; end
  end

  int checks = 0, fails = 0;
  logic [47:0] base = '0;
  int base_ticks = 0;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d, output int ecyc);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0; ecyc = cyc;
  endtask

  // caller is at a falling edge
  task automatic load(input logic [47:0] v);
    bit hit;
    hit = tick; ld_en = 1'b1; ld_stamp = v;
    @(negedge clk); ld_en = 1'b0;
    base = v + (hit ? 48'd4 : 48'd0); base_ticks = ticks;
  endtask

  task automatic read_full(output logic [47:0] v, output int t);
    @(negedge clk); rd_en = 1'b1; rd_idx = 3'd0;
    #0.2 v[7:0] = rd_data; t = ticks;
    @(negedge clk); rd_en = 1'b0;
    for (int k = 1; k < 6; k++) begin
      rd_idx = 3'(k); #0.2 v[8*k +: 8] = rd_data;
    end
    rd_idx = 3'd0;
  endtask

  task automatic check_stamp(input string req);
    logic [47:0] v; int t;
    read_full(v, t);
    chk(v == base + 48'(4 * (t - base_ticks)), req, v, base + 48'(4 * (t - base_ticks)));
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3*DIV) @(negedge clk);
    chk(irq_req == 1'b0, "R1 irq after reset", 48'(irq_req), 48'd0);
    chk(ticks == 0, "R1 no ticks while stopped", 48'(ticks), 48'd0);
    check_stamp("R1 stamp zero");
    chk(irq_vector == 16'h0038, "R7 vector", 48'(irq_vector), 48'h38);
  endtask

  task automatic t_ignore_idle();
    int e;
    io_write(8'hFD, 8'd20, e);
    io_write(8'hFE, 8'd21, e);
    repeat (2*DIV) @(negedge clk);
    chk(ticks == 0, "R5 foreign writes do not start", 48'(ticks), 48'd0);
  endtask

  task automatic t_enable();
    int e, n0;
    n0 = ticks;
    io_write(8'hFE, 8'd20, e);
    repeat (DIV + 3) @(negedge clk);
    chk(ticks == n0 + 1, "R2 one tick after a period", 48'(ticks), 48'(n0 + 1));
    chk(last_tick == e + DIV, "R2 first tick cycle", 48'(last_tick), 48'(e + DIV));
    chk(irq_req == 1'b1, "R7 request set by tick", 48'(irq_req), 48'd1);
  endtask

  task automatic t_period();
    repeat (3*DIV) @(negedge clk);
    chk(last_tick - prev_tick == DIV, "R3 tick spacing", 48'(last_tick - prev_tick), 48'(DIV));
    check_stamp("R6 stamp plus four per tick");
  endtask

  task automatic t_pending();
    chk(irq_req == 1'b1, "R9 request held over ticks", 48'(irq_req), 48'd1);
    chk(ticks >= 4, "R9 ticks kept coming", 48'(ticks), 48'd4);
    check_stamp("R9 no tick skipped");
  endtask

  task automatic t_ack();
    wait_tick();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R7 ack clears request", 48'(irq_req), 48'd0);
  endtask

  task automatic t_ack_collide();
    do @(negedge clk); while (!tick);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq_req == 1'b1, "R8 tick beats ack", 48'(irq_req), 48'd1);
  endtask

  task automatic t_ignore_run();
    int e, n0;
    io_write(8'hFD, 8'd22, e);
    io_write(8'hFE, 8'd23, e);
    n0 = ticks;
    repeat (2*DIV + 2) @(negedge clk);
    chk(ticks >= n0 + 2, "R5 foreign writes do not stop", 48'(ticks), 48'(n0 + 2));
  endtask

  task automatic t_load_tick();
    do @(negedge clk); while (!tick);
    load(48'h0000_1111_22F0);
    chk(base == 48'h0000_1111_22F4, "R10 load with tick adds four", base, 48'h0000_1111_22F4);
    check_stamp("R10 load during tick");
  endtask

  task automatic t_disable();
    int e, n0;
    io_write(8'hFE, 8'd22, e);
    chk(irq_req == 1'b0, "R4 stop withdraws request", 48'(irq_req), 48'd0);
    n0 = ticks;
    repeat (3*DIV) @(negedge clk);
    chk(ticks == n0, "R4 no ticks after stop", 48'(ticks), 48'(n0));
    check_stamp("R4 stamp holds");
  endtask

  task automatic t_carry();
    int e, t; logic [47:0] v;
    @(negedge clk); load(48'h0000_0000_00F8);
    check_stamp("R10 load while idle");
    io_write(8'hFE, 8'd20, e);
    wait_tick(); wait_tick();
    io_write(8'hFE, 8'd22, e);
    read_full(v, t);
    chk(v == 48'h0000_0000_0100, "R6 fraction carries to seconds", v, 48'h100);
  endtask

  task automatic t_wrap();
    int e, t; logic [47:0] v;
    @(negedge clk); load(48'hFFFF_FFFF_FFFC);
    io_write(8'hFE, 8'd20, e);
    wait_tick();
    io_write(8'hFE, 8'd22, e);
    read_full(v, t);
    chk(v == 48'd0, "R12 wrap to zero", v, 48'd0);
  endtask

  task automatic t_snapshot();
    int e; logic [7:0] b0; logic [47:0] ref_v;
    ref_v = 48'h1234_5678_9AFC;
    @(negedge clk); load(ref_v);
    io_write(8'hFE, 8'd20, e);
    @(negedge clk); rd_en = 1'b1; rd_idx = 3'd0; #0.2 b0 = rd_data;
    @(negedge clk); rd_en = 1'b0;
    chk(b0 == 8'hFC, "R11 live fraction byte", 48'(b0), 48'hFC);
    repeat (DIV + 2) @(negedge clk);
    for (int k = 1; k < 6; k++) begin
      rd_idx = 3'(k); #0.2;
      chk(rd_data == ref_v[8*k +: 8], "R11 snapshot byte", 48'(rd_data), 48'(ref_v[8*k +: 8]));
    end
    rd_idx = 3'd6; #0.2;
    chk(rd_data == 8'h00, "R11 index 6 reads zero", 48'(rd_data), 48'd0);
    rd_idx = 3'd0;
    check_stamp("R11 fresh coherent read");
    io_write(8'hFE, 8'd22, e);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ignore_idle();
    t_enable();
    t_period();
    t_pending();
    t_ack();
    t_ack_collide();
    t_ignore_run();
    t_load_tick();
    t_disable();
    t_carry();
    t_wrap();
    t_snapshot();
    finish_up();
  end
endmodule